// File: doc/BRIEF.md
# List Path-Metric Pruning Unit

This unit holds the four path metrics of a list decoder for polar codes with a list size of four, and prunes the list when the decoder reaches a node that needs list expansion. At such a node, a metric generator for each path offers four candidate node metrics, each paired with an 8-bit candidate code word. The unit adds each node metric to the metric of its own path, which gives sixteen extended metrics. It keeps the four smallest, where a smaller value means a more reliable path. These four become the new path metrics. With each survivor the unit reports the index of the path it came from and the code word it carries, so that the decoder can copy path state and write back partial sums.

The selection runs as a pipeline of four register stages: extension, a first tier of two 8-to-4 minimum selectors, a second 8-to-4 selector, and write-back. A single-cycle start pulse therefore yields a single-cycle valid pulse four clock edges later. A synchronous clear returns every metric to zero at the start of a codeword. A per-path enable marks paths that do not yet exist, so that they cannot survive.

Top module: `lpm_prune`

## Requirements
- R1: After reset, and after any clear, every path metric on pm_o reads 0 and valid_o is low. pm_o changes only in the cycle where valid_o is high or just after a clear.
- R2: The extended metric of input entry i = 4p+k (path p, candidate k) is pm[p] + nm_i[i]. It saturates at 2^MW-1 and never wraps.
- R3: On valid_o, pm_o[0..3] hold the four smallest extended metrics in ascending order, with slot 0 the smallest. They remain as the path metrics until the next result.
- R4: For survivor slot j, parent_o[j] holds the path index p = i/4 of the winning entry i, and code_o[j] holds code_i[i] of that entry.
- R5: Equal extended metrics are ordered by input position, with the lower index i ranked first.
- R6: A path whose bit in path_en_i is 0 contributes extended metrics of all ones (2^MW-1) for all four of its entries.
- R7: valid_o goes high for exactly one cycle, on the fourth rising edge counted from the edge that accepts start_i, which is the first of the four.
- R8: A start_i that arrives while an earlier pruning is still in the pipeline is ignored. It produces no extra result and does not change the result already in flight.
- R9: clear_i is synchronous. It takes priority over start_i and cancels any pruning in flight, so no valid_o follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the metrics for a new codeword |
| start_i | input | 1 | Pulse that launches one pruning step |
| path_en_i | input | 4 | Per-path enable, bit p for path p |
| nm_i | input | 16 x MW | Node metrics, entry 4p+k is candidate k of path p |
| code_i | input | 16 x CW | Candidate code word for each entry |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| pm_o | output | 4 x MW | Current path metrics, ascending after each result |
| parent_o | output | 4 x 2 | Source path index of each survivor |
| code_o | output | 4 x CW | Code word of each survivor |

## Verification
The hardest situation to reach from the ports is a selection where saturated valid paths, disabled paths and exact ties all compete at the same all-ones value. In that case only the position rule decides the winners. The bench builds this case by feeding maximum node metrics repeatedly until the metrics stick at the top, while leaving some paths disabled. It also sweeps every enable pattern with small node values, which produce frequent ties. A bench model that selects by metric and then by position predicts each survivor. Separate sequences hold start_i high across the busy window and raise clear_i in the middle of a pruning step.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    localparam int LIST  = 4;              // decoding paths
    localparam int NPP   = 4;              // node metrics offered per path
    localparam int NEXT  = LIST * NPP;     // extended metrics per step
    localparam int IDXW  = $clog2(NEXT);   // entry index width
    localparam int PW    = $clog2(LIST);   // path index width
    localparam int HALF  = NEXT / 2;       // inputs per first-tier selector
endpackage

// File: rtl/lpm_extend.sv
module lpm_extend
    import lpm_pkg::*;
#(
    parameter int MW = 10,
    parameter int CW = 8,
    localparam int KW = MW + IDXW + CW
) (
    input  logic [LIST-1:0][MW-1:0] pm_i,
    input  logic [NEXT-1:0][MW-1:0] nm_i,
    input  logic [NEXT-1:0][CW-1:0] code_i,
    input  logic [LIST-1:0]         en_i,
    output logic [NEXT-1:0][KW-1:0] key_o
);
    // key = {metric, entry index, code}; the index makes every key unique
    for (genvar i = 0; i < NEXT; i++) begin : g_ext
        localparam int P = i / NPP;
        logic [MW:0]   sum;
        logic [MW-1:0] met;
        assign sum = {1'b0, pm_i[P]} + {1'b0, nm_i[i]};
        assign met = (!en_i[P] || sum[MW]) ? {MW{1'b1}} : sum[MW-1:0];
        assign key_o[i] = {met, IDXW'(i), code_i[i]};
    end
endmodule

// File: rtl/lpm_min8to4.sv
module lpm_min8to4 #(
    parameter int KW = 22
) (
    input  logic [7:0][KW-1:0] in_i,
    output logic [3:0][KW-1:0] out_o
);
    function automatic logic [3:0][KW-1:0] cx(input logic [3:0][KW-1:0] v,
                                              input int lo, input int hi);
        logic [3:0][KW-1:0] r;
        r = v;
        if (v[hi] < v[lo]) begin
            r[lo] = v[hi];
            r[hi] = v[lo];
        end
        return r;
    endfunction

    function automatic logic [3:0][KW-1:0] sort4(input logic [3:0][KW-1:0] v);
        logic [3:0][KW-1:0] a;
        a = cx(v, 0, 1);
        a = cx(a, 2, 3);
        a = cx(a, 0, 2);
        a = cx(a, 1, 3);
        a = cx(a, 1, 2);
        return a;
    endfunction

    logic [3:0][KW-1:0] lo_s, hi_s, bit_s;

    always_comb begin
        lo_s = sort4(in_i[3:0]);
        hi_s = sort4(in_i[7:4]);
        // half-cleaner: the four smallest, as a bitonic sequence
        for (int i = 0; i < 4; i++) begin
            bit_s[i] = (lo_s[i] < hi_s[3-i]) ? lo_s[i] : hi_s[3-i];
        end
        bit_s = cx(bit_s, 0, 2);
        bit_s = cx(bit_s, 1, 3);
        bit_s = cx(bit_s, 0, 1);
        bit_s = cx(bit_s, 2, 3);
        out_o = bit_s;
    end
endmodule

// File: rtl/lpm_prune.sv
module lpm_prune
    import lpm_pkg::*;
#(
    parameter int MW = 10,
    parameter int CW = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    start_i,
    input  logic [LIST-1:0]         path_en_i,
    input  logic [NEXT-1:0][MW-1:0] nm_i,
    input  logic [NEXT-1:0][CW-1:0] code_i,
    output logic                    valid_o,
    output logic [LIST-1:0][MW-1:0] pm_o,
    output logic [LIST-1:0][PW-1:0] parent_o,
    output logic [LIST-1:0][CW-1:0] code_o
);
    localparam int KW    = MW + IDXW + CW;
    localparam int M_LSB = IDXW + CW;

    typedef struct packed {
        logic                    s1_v;
        logic [NEXT-1:0][KW-1:0] s1_key;
        logic                    s2_v;
        logic [7:0][KW-1:0]      s2_key;
        logic                    s3_v;
        logic [3:0][KW-1:0]      s3_key;
        logic                    out_v;
        logic [LIST-1:0][MW-1:0] pm;
        logic [LIST-1:0][PW-1:0] par;
        logic [LIST-1:0][CW-1:0] code;
    } st_t;

    st_t st_d, st_q;

    logic [NEXT-1:0][KW-1:0] ext_key;
    logic [3:0][KW-1:0]      t1a, t1b, t2;
    logic                    busy;

    lpm_extend #(.MW(MW), .CW(CW)) i_ext (
        .pm_i   (st_q.pm),
        .nm_i   (nm_i),
        .code_i (code_i),
        .en_i   (path_en_i),
        .key_o  (ext_key)
    );

    lpm_min8to4 #(.KW(KW)) i_tier1a (.in_i(st_q.s1_key[HALF-1:0]),    .out_o(t1a));
    lpm_min8to4 #(.KW(KW)) i_tier1b (.in_i(st_q.s1_key[NEXT-1:HALF]), .out_o(t1b));
    lpm_min8to4 #(.KW(KW)) i_tier2  (.in_i(st_q.s2_key),              .out_o(t2));

    assign busy = st_q.s1_v | st_q.s2_v | st_q.s3_v;

    always_comb begin
        st_d       = st_q;
        st_d.out_v = 1'b0;

        st_d.s1_v = start_i && !busy;
        if (start_i && !busy) st_d.s1_key = ext_key;

        st_d.s2_v = st_q.s1_v;
        if (st_q.s1_v) st_d.s2_key = {t1b, t1a};

        st_d.s3_v = st_q.s2_v;
        if (st_q.s2_v) st_d.s3_key = t2;

        if (st_q.s3_v) begin
            st_d.out_v = 1'b1;
            for (int j = 0; j < LIST; j++) begin
                st_d.pm[j]   = st_q.s3_key[j][KW-1:M_LSB];
                st_d.par[j]  = st_q.s3_key[j][M_LSB-1:M_LSB-PW];
                st_d.code[j] = st_q.s3_key[j][CW-1:0];
            end
        end

        if (clear_i) begin
            st_d.s1_v  = 1'b0;
            st_d.s2_v  = 1'b0;
            st_d.s3_v  = 1'b0;
            st_d.out_v = 1'b0;
            st_d.pm    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o  = st_q.out_v;
    assign pm_o     = st_q.pm;
    assign parent_o = st_q.par;
    assign code_o   = st_q.code;
endmodule

// File: rtl/lpm_prune_chk.sv
module lpm_prune_chk #(
    parameter int MW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               clear_i,
    input logic               busy,
    input logic               valid_o,
    input logic [3:0][MW-1:0] pm_o
);
    logic acc;
    assign acc = start_i && !busy && !clear_i;

    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(acc, 4));

    p_sorted_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (pm_o[0] <= pm_o[1] && pm_o[1] <= pm_o[2] && pm_o[2] <= pm_o[3]));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pm_o == '0 && !valid_o));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pm_o) |-> (valid_o || $past(clear_i)));
endmodule

bind lpm_prune lpm_prune_chk #(.MW(MW)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .clear_i (clear_i),
    .busy    (busy),
    .valid_o (valid_o),
    .pm_o    (pm_o)
);

// File: tb/test_lpm_prune.sv
module test_lpm_prune;
    localparam int MW  = 10;
    localparam int CW  = 8;
    localparam int TOP = (1 << MW) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                clear_i = 1'b0;
    logic                start_i = 1'b0;
    logic [3:0]          path_en_i = '0;
    logic [15:0][MW-1:0] nm_i = '0;
    logic [15:0][CW-1:0] code_i = '0;
    logic                valid_o;
    logic [3:0][MW-1:0]  pm_o;
    logic [3:0][1:0]     parent_o;
    logic [3:0][CW-1:0]  code_o;

    int checks = 0;
    int errors = 0;
    int mpm[4];
    int exp_pm[4], exp_par[4], exp_code[4];
    logic [31:0] rs = 32'h1234_5678;

    lpm_prune #(.MW(MW), .CW(CW)) i_lpm_prune (.*);

    always #2 clk = ~clk;

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference: extend with saturation, then pick by (metric, position)
    task automatic model();
        int  ext[16];
        bit  taken[16];
        for (int i = 0; i < 16; i++) begin
            int p = i / 4;
            int s = mpm[p] + int'(nm_i[i]);
            ext[i] = !path_en_i[p] ? TOP : (s > TOP ? TOP : s);
            taken[i] = 0;
        end
        for (int j = 0; j < 4; j++) begin
            int b = -1;
            for (int i = 0; i < 16; i++)
                if (!taken[i] && (b < 0 || ext[i] < ext[b])) b = i;
            taken[b] = 1;
            exp_pm[j] = ext[b]; exp_par[j] = b / 4; exp_code[j] = int'(code_i[b]);
        end
    endtask

    task automatic check_result(input string tag);
        for (int j = 0; j < 4; j++) begin
            chk({tag, " metric"}, int'(pm_o[j]), exp_pm[j]);
            chk({tag, " parent R4"}, int'(parent_o[j]), exp_par[j]);
            chk({tag, " code R4"}, int'(code_o[j]), exp_code[j]);
        end
    endtask

    // inputs already set at a negedge; runs one step and checks it
    task automatic step(input string tag);
        model();
        start_i = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk); @(negedge clk);
            start_i = 1'b0;
            chk("R7 early valid", int'(valid_o), 0);
        end
        @(posedge clk); @(negedge clk);
        chk("R7 valid on fourth edge", int'(valid_o), 1);
        check_result(tag);
        for (int j = 0; j < 4; j++) mpm[j] = exp_pm[j];
        @(posedge clk); @(negedge clk);
        chk("R7 single pulse", int'(valid_o), 0);
        check_result({tag, " R3 held"});
    endtask

    task automatic do_clear();
        clear_i = 1'b1;
        @(posedge clk); @(negedge clk);
        clear_i = 1'b0;
        for (int j = 0; j < 4; j++) mpm[j] = 0;
        for (int j = 0; j < 4; j++) chk("R1 clear metric", int'(pm_o[j]), 0);
    endtask

    task automatic rand_inputs(input int mask);
        for (int i = 0; i < 16; i++) begin
            rs = nxt(rs); nm_i[i]   = MW'(rs & mask);
            rs = nxt(rs); code_i[i] = CW'(rs);
        end
    endtask

    initial begin
        for (int j = 0; j < 4; j++) mpm[j] = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(valid_o), 0);
        for (int j = 0; j < 4; j++) chk("R1 reset metric", int'(pm_o[j]), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: all equal node metrics, path 0 positions win
        path_en_i = 4'hF;
        for (int i = 0; i < 16; i++) begin nm_i[i] = 5; code_i[i] = CW'(i * 7); end
        step("R5 all equal");
        chk("R5 winner path", int'(parent_o[3]), 0);

        // R6: only path 0 enabled, its large metrics still beat disabled paths
        do_clear();
        path_en_i = 4'b0001;
        for (int i = 0; i < 16; i++) begin nm_i[i] = (i < 4) ? 500 : 0; code_i[i] = CW'(i); end
        step("R6 one path");
        for (int j = 0; j < 4; j++) chk("R6 parent", int'(parent_o[j]), 0);

        // R2/R6: saturate enabled paths so they tie with disabled ones
        path_en_i = 4'b0101;
        for (int r = 0; r < 4; r++) begin
            rand_inputs(TOP); for (int i = 0; i < 16; i++) nm_i[i] = MW'(TOP - (i % 3));
            step("R2 saturation");
        end
        chk("R2 saturated top", int'(pm_o[3]), TOP);

        // sweep of enable patterns with small and full-range metrics
        for (int r = 0; r < 320; r++) begin
            if (r % 6 == 0) do_clear();
            path_en_i = 4'((r % 15) + 1);
            rand_inputs((r % 2 == 0) ? 7 : TOP);
            step("R3 sweep");
        end
        path_en_i = 4'h0;
        rand_inputs(63);
        step("R6 none enabled");

        // R8: start held through the busy window, data changed after acceptance
        do_clear();
        path_en_i = 4'hF;
        rand_inputs(255);
        model();
        start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        rand_inputs(3);
        for (int c = 0; c < 2; c++) begin
            @(posedge clk); @(negedge clk);
            chk("R8 no early valid", int'(valid_o), 0);
        end
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        chk("R8 one result", int'(valid_o), 1);
        check_result("R8 first data");
        for (int j = 0; j < 4; j++) mpm[j] = exp_pm[j];
        for (int c = 0; c < 6; c++) begin
            @(posedge clk); @(negedge clk);
            chk("R8 no extra valid", int'(valid_o), 0);
        end

        // R9: clear in flight cancels the result
        rand_inputs(255);
        start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        clear_i = 1'b1;
        @(posedge clk); @(negedge clk);
        clear_i = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(posedge clk); @(negedge clk);
            chk("R9 cancelled valid", int'(valid_o), 0);
        end
        for (int j = 0; j < 4; j++) begin
            chk("R9 metric zero", int'(pm_o[j]), 0);
            mpm[j] = 0;
        end

        // R9: clear beats a simultaneous start
        start_i = 1'b1; clear_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0; clear_i = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(posedge clk); @(negedge clk);
            chk("R9 start dropped", int'(valid_o), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule